// File: doc/BRIEF.md
# SPI In-System Programming Target Controller

This block is the target side of a serial programming port. An external programmer uses it to erase, write and read back two on-chip nonvolatile arrays: a code array and a smaller data array. The link has three wires: a serial clock `sck`, serial data in `mosi` and serial data out `miso`. The block runs only while `prog_mode` is high. It never clocks logic from `sck`. Instead it passes `sck` and `mosi` through a synchroniser on the system clock and acts on the edges it detects there, so `sck` must stay below one sixteenth of the system clock.

Every instruction is a 32-bit frame of four bytes, sent MSB first: opcode, address high, address low, then a data byte. The programmer supplies the data byte on writes, and the block returns its response in that byte on reads. A new session is locked. Only a correct enable frame unlocks it. After that the block accepts the following commands:
- chip erase;
- byte write into either array;
- loading of a page buffer, and commit of that buffer into either array;
- byte read;
- status poll.

Writes, commits and erase each start a self-timed busy interval. While that interval runs, every frame except the status poll is dropped. The arrays are modelled as simple synchronous RAMs inside the block. The defaults give a 3072-byte code array so that the default build stays small. Set `CODE_BYTES` to 12288 to get the full 0000H–2FFFH code space.

The serial port has no valid/ready handshake, and there is no back-pressure. The programmer paces itself with the status poll. A frame sent while the block is busy is simply lost.

Top module: `isp_target`

## Requirements
- R1: While `prog_mode` is low, frames have no effect and `miso` stays 0. Driving `prog_mode` low closes the session, so the next session starts locked again.
- R2: Until the session is unlocked, every frame is ignored and returns 00H. This includes writes, reads and status polls.
- R3: A frame with opcode 10H and A5H in the second byte unlocks the session. An opcode of 10H with any other second byte leaves the session locked.
- R4: Opcode 20H sets every byte of both arrays to FFH.
- R5: Opcode 40H writes the fourth byte into the code array, and opcode 41H writes it into the data array. In both cases the address is {second byte, third byte}.
- R6: Opcodes 30H and 31H return the addressed code or data byte in the fourth byte of the same frame. `mosi` is sampled on `sck` rising edges, and `miso` changes only after `sck` falling edges, MSB first. An unknown opcode returns 00H and changes nothing.
- R7: Opcode 60H loads the fourth byte into the page buffer, at the offset given by the low log2(`PAGE_BYTES`) address bits. Opcode 70H (code) or 71H (data) copies the whole buffer into the page that contains the address. The buffer then refills with FFH, so any byte that was not loaded writes FFH.
- R8: A byte write, a page commit or an erase starts a busy interval of at least `WRITE_CYCLES` system clocks. Opcode F0H returns the busy flag in bit 0 of the fourth byte.
- R9: Any frame other than a status poll is discarded while the block is busy.
- R10: The address is reduced modulo the size of the addressed array. The two address spaces never alias each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_mode | input | 1 | High holds the device in programming mode |
| sck | input | 1 | Serial clock from the programmer |
| mosi | input | 1 | Serial data into the block |
| miso | output | 1 | Serial data out of the block |

## Verification
The bench builds the block with `CODE_BYTES`=96, `DATA_BYTES`=64, `PAGE_BYTES`=8 and `WRITE_CYCLES`=2000.
- A 96-byte code array is not a power of two, so an address such as 0061H or 012DH exercises the modulo wrap. With 64 data bytes, the same addresses land in different cells of the two arrays.
- An 8-byte page lets the bench cover partly loaded pages and the FFH fill within a few frames.
- 2000 cycles is longer than two whole frames. A frame sent just after a write therefore falls inside the busy window, and status polls can bracket the end of that window.

// File: rtl/isp_pkg.sv
package isp_pkg;
  localparam logic [7:0] OP_ENABLE  = 8'h10;
  localparam logic [7:0] ENABLE_KEY = 8'hA5;
  localparam logic [7:0] OP_ERASE   = 8'h20;
  localparam logic [7:0] OP_RD_CODE = 8'h30;
  localparam logic [7:0] OP_RD_DATA = 8'h31;
  localparam logic [7:0] OP_WR_CODE = 8'h40;
  localparam logic [7:0] OP_WR_DATA = 8'h41;
  localparam logic [7:0] OP_PG_LOAD = 8'h60;
  localparam logic [7:0] OP_PG_CODE = 8'h70;
  localparam logic [7:0] OP_PG_DATA = 8'h71;
  localparam logic [7:0] OP_STATUS  = 8'hF0;

  typedef enum logic [1:0] {RSP_NONE, RSP_CODE, RSP_DATA, RSP_STAT} rsp_kind_e;
  typedef enum logic [1:0] {SW_IDLE, SW_ERASE, SW_PAGE} sweep_e;
endpackage

// File: rtl/isp_sck_sync.sv
module isp_sck_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic mosi,
  output logic rise,
  output logic fall,
  output logic mosi_s
);
  logic [STAGES:0]   sck_pipe;
  logic [STAGES-1:0] mosi_pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_pipe  <= '0;
      mosi_pipe <= '0;
    end else begin
      sck_pipe  <= {sck_pipe[STAGES-1:0], sck};
      mosi_pipe <= {mosi_pipe[STAGES-2:0], mosi};
    end
  end

  assign rise   = sck_pipe[STAGES-1] & ~sck_pipe[STAGES];
  assign fall   = ~sck_pipe[STAGES-1] & sck_pipe[STAGES];
  assign mosi_s = mosi_pipe[STAGES-1];
endmodule

// File: rtl/isp_frame_rx.sv
module isp_frame_rx #(
  parameter int FRAME_BITS = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  prog_mode,
  input  logic                  rise,
  input  logic                  fall,
  input  logic                  mosi_s,
  input  logic [7:0]            resp,
  output logic [FRAME_BITS-1:0] frame,
  output logic                  hdr_v,
  output logic                  frame_v,
  output logic                  miso
);
  localparam int CNT_W    = $clog2(FRAME_BITS);
  localparam int LAST     = FRAME_BITS - 1;
  localparam int HDR_LAST = FRAME_BITS - 9;
  localparam int TX_AT    = FRAME_BITS - 8;

  logic [CNT_W-1:0] cnt;
  logic [7:0]       out_sr;
  logic             tx_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      frame   <= '0;
      hdr_v   <= 1'b0;
      frame_v <= 1'b0;
      out_sr  <= '0;
      tx_on   <= 1'b0;
    end else begin
      hdr_v   <= 1'b0;
      frame_v <= 1'b0;
      if (!prog_mode) begin
        cnt   <= '0;
        tx_on <= 1'b0;
      end else begin
        if (rise) begin
          frame   <= {frame[FRAME_BITS-2:0], mosi_s};
          hdr_v   <= (cnt == CNT_W'(HDR_LAST));
          frame_v <= (cnt == CNT_W'(LAST));
          cnt     <= (cnt == CNT_W'(LAST)) ? '0 : cnt + 1'b1;
        end
        if (fall) begin
          if (cnt == CNT_W'(TX_AT)) begin
            out_sr <= resp;
            tx_on  <= 1'b1;
          end else if (cnt == '0) begin
            tx_on <= 1'b0;
          end else begin
            out_sr <= {out_sr[6:0], 1'b0};
          end
        end
      end
    end
  end

  assign miso = prog_mode & tx_on & out_sr[7];
endmodule

// File: rtl/isp_ram.sv
module isp_ram #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [7:0]    wd,
  input  logic [AW-1:0] ra,
  output logic [7:0]    q
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    q <= mem[ra];
  end
endmodule

// File: rtl/isp_nvm_ctrl.sv
module isp_nvm_ctrl
  import isp_pkg::*;
#(
  parameter int CODE_BYTES   = 3072,
  parameter int DATA_BYTES   = 2048,
  parameter int PAGE_BYTES   = 64,
  parameter int WRITE_CYCLES = 96000,
  localparam int CAW = $clog2(CODE_BYTES),
  localparam int DAW = $clog2(DATA_BYTES)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           prog_mode,
  input  logic           hdr_v,
  input  logic           frame_v,
  input  logic [31:0]    frame,
  input  logic [7:0]     code_q,
  input  logic [7:0]     data_q,
  output logic [7:0]     resp,
  output logic           en_q,
  output logic           busy_q,
  output logic           code_we,
  output logic [CAW-1:0] code_wa,
  output logic [7:0]     code_wd,
  output logic [CAW-1:0] code_ra,
  output logic           data_we,
  output logic [DAW-1:0] data_wa,
  output logic [7:0]     data_wd,
  output logic [DAW-1:0] data_ra
);
  localparam int PBW  = $clog2(PAGE_BYTES);
  localparam int MAXB = (CODE_BYTES > DATA_BYTES) ? CODE_BYTES : DATA_BYTES;
  localparam int SWW  = $clog2(MAXB + 1);
  localparam int TW   = $clog2(WRITE_CYCLES + 1);

  function automatic logic [CAW-1:0] code_idx(input logic [15:0] a);
    logic [15:0] r;
    r = a % 16'(CODE_BYTES);
    return r[CAW-1:0];
  endfunction

  function automatic logic [DAW-1:0] data_idx(input logic [15:0] a);
    logic [15:0] r;
    r = a % 16'(DATA_BYTES);
    return r[DAW-1:0];
  endfunction

  // header fields (valid with hdr_v) and full-frame fields (valid with frame_v)
  logic [7:0]  h_op, f_op, f_ah, f_din;
  logic [15:0] h_addr, f_addr;
  assign h_op   = frame[23:16];
  assign h_addr = frame[15:0];
  assign f_op   = frame[31:24];
  assign f_ah   = frame[23:16];
  assign f_addr = frame[23:8];
  assign f_din  = frame[7:0];

  logic           f_ok, start_busy;
  logic [CAW-1:0] f_cidx;
  logic [DAW-1:0] f_didx;
  assign f_ok   = frame_v && prog_mode && en_q && !busy_q;
  assign f_cidx = code_idx(f_addr);
  assign f_didx = data_idx(f_addr);
  assign start_busy = f_ok && (f_op == OP_ERASE || f_op == OP_WR_CODE || f_op == OP_WR_DATA ||
                               f_op == OP_PG_CODE || f_op == OP_PG_DATA);

  sweep_e         sw_mode;
  logic [SWW-1:0] sw_idx;
  logic           sw_arr;
  logic [CAW-1:0] sw_cbase;
  logic [DAW-1:0] sw_dbase;
  logic [TW-1:0]  tmr;
  logic [7:0]     pbuf [PAGE_BYTES];
  rsp_kind_e      rkind;
  logic [PBW-1:0] pg_off;
  assign pg_off = sw_idx[PBW-1:0];

  // session lock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else if (!prog_mode) en_q <= 1'b0;
    else if (frame_v && !busy_q && f_op == OP_ENABLE && f_ah == ENABLE_KEY) en_q <= 1'b1;
  end

  // self-timed busy interval and sweep engine
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      tmr      <= '0;
      sw_mode  <= SW_IDLE;
      sw_idx   <= '0;
      sw_arr   <= 1'b0;
      sw_cbase <= '0;
      sw_dbase <= '0;
    end else begin
      if (start_busy) begin
        busy_q <= 1'b1;
        tmr    <= TW'(WRITE_CYCLES - 1);
      end else if (busy_q) begin
        if (tmr != '0) tmr <= tmr - 1'b1;
        else if (sw_mode == SW_IDLE) busy_q <= 1'b0;
      end

      if (start_busy && f_op == OP_ERASE) begin
        sw_mode <= SW_ERASE;
        sw_idx  <= '0;
      end else if (start_busy && (f_op == OP_PG_CODE || f_op == OP_PG_DATA)) begin
        sw_mode  <= SW_PAGE;
        sw_idx   <= '0;
        sw_arr   <= (f_op == OP_PG_DATA);
        sw_cbase <= f_cidx & ~CAW'(PAGE_BYTES - 1);
        sw_dbase <= f_didx & ~DAW'(PAGE_BYTES - 1);
      end else if (sw_mode == SW_ERASE) begin
        if (sw_idx == SWW'(MAXB - 1)) sw_mode <= SW_IDLE;
        else sw_idx <= sw_idx + 1'b1;
      end else if (sw_mode == SW_PAGE) begin
        if (sw_idx == SWW'(PAGE_BYTES - 1)) sw_mode <= SW_IDLE;
        else sw_idx <= sw_idx + 1'b1;
      end
    end
  end

  // page buffer: loaded by frames, drained (and refilled with FFH) by a commit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PAGE_BYTES; i++) pbuf[i] <= 8'hFF;
    end else if (sw_mode == SW_PAGE) begin
      pbuf[pg_off] <= 8'hFF;
    end else if (f_ok && f_op == OP_PG_LOAD) begin
      pbuf[f_addr[PBW-1:0]] <= f_din;
    end
  end

  // array write ports
  always_comb begin
    code_we = 1'b0;
    code_wa = f_cidx;
    code_wd = f_din;
    data_we = 1'b0;
    data_wa = f_didx;
    data_wd = f_din;
    if (sw_mode == SW_ERASE) begin
      code_we = (sw_idx < SWW'(CODE_BYTES));
      code_wa = sw_idx[CAW-1:0];
      code_wd = 8'hFF;
      data_we = (sw_idx < SWW'(DATA_BYTES));
      data_wa = sw_idx[DAW-1:0];
      data_wd = 8'hFF;
    end else if (sw_mode == SW_PAGE) begin
      code_we = !sw_arr;
      code_wa = sw_cbase | CAW'(pg_off);
      code_wd = pbuf[pg_off];
      data_we = sw_arr;
      data_wa = sw_dbase | DAW'(pg_off);
      data_wd = pbuf[pg_off];
    end else if (f_ok) begin
      code_we = (f_op == OP_WR_CODE);
      data_we = (f_op == OP_WR_DATA);
    end
  end

  // response selection, decided once the header bytes are in
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rkind   <= RSP_NONE;
      code_ra <= '0;
      data_ra <= '0;
    end else if (hdr_v) begin
      rkind <= RSP_NONE;
      if (prog_mode && en_q) begin
        if (h_op == OP_STATUS) begin
          rkind <= RSP_STAT;
        end else if (!busy_q && h_op == OP_RD_CODE) begin
          rkind   <= RSP_CODE;
          code_ra <= code_idx(h_addr);
        end else if (!busy_q && h_op == OP_RD_DATA) begin
          rkind   <= RSP_DATA;
          data_ra <= data_idx(h_addr);
        end
      end
    end
  end

  always_comb begin
    unique case (rkind)
      RSP_CODE: resp = code_q;
      RSP_DATA: resp = data_q;
      RSP_STAT: resp = {7'b0, busy_q};
      default:  resp = 8'h00;
    endcase
  end
endmodule

// File: rtl/isp_target.sv
module isp_target #(
  parameter int CODE_BYTES   = 3072,
  parameter int DATA_BYTES   = 2048,
  parameter int PAGE_BYTES   = 64,
  parameter int WRITE_CYCLES = 96000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic prog_mode,
  input  logic sck,
  input  logic mosi,
  output logic miso
);
  localparam int CAW = $clog2(CODE_BYTES);
  localparam int DAW = $clog2(DATA_BYTES);

  logic           sck_rise, sck_fall, mosi_s;
  logic [31:0]    frame;
  logic           hdr_v, frame_v;
  logic [7:0]     resp, code_q, data_q, code_wd, data_wd;
  logic           en_q, busy_q, code_we, data_we;
  logic [CAW-1:0] code_wa, code_ra;
  logic [DAW-1:0] data_wa, data_ra;

  isp_sck_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .sck(sck), .mosi(mosi),
    .rise(sck_rise), .fall(sck_fall), .mosi_s(mosi_s)
  );

  isp_frame_rx #(.FRAME_BITS(32)) rx_i (
    .clk(clk), .rst_n(rst_n), .prog_mode(prog_mode),
    .rise(sck_rise), .fall(sck_fall), .mosi_s(mosi_s), .resp(resp),
    .frame(frame), .hdr_v(hdr_v), .frame_v(frame_v), .miso(miso)
  );

  isp_nvm_ctrl #(
    .CODE_BYTES(CODE_BYTES), .DATA_BYTES(DATA_BYTES),
    .PAGE_BYTES(PAGE_BYTES), .WRITE_CYCLES(WRITE_CYCLES)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .prog_mode(prog_mode),
    .hdr_v(hdr_v), .frame_v(frame_v), .frame(frame),
    .code_q(code_q), .data_q(data_q), .resp(resp),
    .en_q(en_q), .busy_q(busy_q),
    .code_we(code_we), .code_wa(code_wa), .code_wd(code_wd), .code_ra(code_ra),
    .data_we(data_we), .data_wa(data_wa), .data_wd(data_wd), .data_ra(data_ra)
  );

  isp_ram #(.DEPTH(CODE_BYTES), .AW(CAW)) code_ram_i (
    .clk(clk), .we(code_we), .wa(code_wa), .wd(code_wd), .ra(code_ra), .q(code_q)
  );

  isp_ram #(.DEPTH(DATA_BYTES), .AW(DAW)) data_ram_i (
    .clk(clk), .we(data_we), .wa(data_wa), .wd(data_wd), .ra(data_ra), .q(data_q)
  );
endmodule

// File: rtl/isp_target_chk.sv
module isp_target_chk #(
  parameter int CODE_BYTES = 3072,
  parameter int CAW        = 12
) (
  input logic           clk,
  input logic           rst_n,
  input logic           prog_mode,
  input logic           miso,
  input logic           en_q,
  input logic           busy_q,
  input logic           frame_v,
  input logic           sck_fall,
  input logic           code_we,
  input logic [CAW-1:0] code_wa
);
  // R1
  prog_off_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_mode |=> !en_q);

  // R3
  unlock_from_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_q) |-> $past(frame_v));

  // R6
  miso_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_mode && !sck_fall) |=> ($stable(miso) || !prog_mode));

  // R8
  busy_from_session_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(frame_v && en_q));

  // R8
  idle_write_arms_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (code_we && !busy_q) |=> busy_q);

  // R10
  code_addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    code_we |-> ({1'b0, code_wa} < (CAW+1)'(CODE_BYTES)));
endmodule

bind isp_target isp_target_chk #(.CODE_BYTES(CODE_BYTES), .CAW(CAW)) chk_i (
  .clk(clk), .rst_n(rst_n), .prog_mode(prog_mode), .miso(miso),
  .en_q(en_q), .busy_q(busy_q), .frame_v(frame_v), .sck_fall(sck_fall),
  .code_we(code_we), .code_wa(code_wa)
);

// File: tb/isp_target_tb.sv
module isp_target_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 10;
  localparam int NVEC       = 25;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prog_mode = 1'b0;
  logic sck = 1'b0;
  logic mosi = 1'b0;
  logic miso;
  int   errors = 0;
  int   checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  isp_target #(
    .CODE_BYTES(96), .DATA_BYTES(64), .PAGE_BYTES(8), .WRITE_CYCLES(2000)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .prog_mode(prog_mode),
    .sck(sck), .mosi(mosi), .miso(miso)
  );

  // {req, opcode, addr_hi, addr_lo, data_in, expected response, poll until idle}
  localparam logic [48:0] VEC [NVEC] = '{
    {8'd4,  8'h20, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1}, // R4 erase
    {8'd4,  8'h30, 8'h00, 8'h05, 8'h00, 8'hFF, 1'b0}, // R4 code erased
    {8'd4,  8'h31, 8'h00, 8'h3F, 8'h00, 8'hFF, 1'b0}, // R4 data erased
    {8'd5,  8'h40, 8'h00, 8'h05, 8'h5A, 8'h00, 1'b1}, // R5 code write
    {8'd5,  8'h41, 8'h00, 8'h05, 8'hC3, 8'h00, 1'b1}, // R5 data write
    {8'd5,  8'h30, 8'h00, 8'h05, 8'h00, 8'h5A, 1'b0}, // R5 read back
    {8'd10, 8'h31, 8'h00, 8'h05, 8'h00, 8'hC3, 1'b0}, // R10 separate spaces
    {8'd10, 8'h40, 8'h00, 8'h61, 8'h77, 8'h00, 1'b1}, // R10 97 wraps to 1
    {8'd10, 8'h30, 8'h00, 8'h01, 8'h00, 8'h77, 1'b0}, // R10
    {8'd10, 8'h31, 8'h00, 8'h45, 8'h00, 8'hC3, 1'b0}, // R10 69 wraps to 5
    {8'd7,  8'h60, 8'h00, 8'h02, 8'h11, 8'h00, 1'b0}, // R7 load offset 2
    {8'd7,  8'h60, 8'h00, 8'h0F, 8'h22, 8'h00, 1'b0}, // R7 load offset 7
    {8'd7,  8'h71, 8'h00, 8'h10, 8'h00, 8'h00, 1'b1}, // R7 commit data page 16
    {8'd7,  8'h31, 8'h00, 8'h12, 8'h00, 8'h11, 1'b0}, // R7
    {8'd7,  8'h31, 8'h00, 8'h17, 8'h00, 8'h22, 1'b0}, // R7
    {8'd7,  8'h31, 8'h00, 8'h10, 8'h00, 8'hFF, 1'b0}, // R7 unloaded byte
    {8'd7,  8'h60, 8'h00, 8'h03, 8'h33, 8'h00, 1'b0}, // R7
    {8'd7,  8'h70, 8'h00, 8'h28, 8'h00, 8'h00, 1'b1}, // R7 commit code page 40
    {8'd7,  8'h30, 8'h00, 8'h2B, 8'h00, 8'h33, 1'b0}, // R7
    {8'd7,  8'h30, 8'h00, 8'h2A, 8'h00, 8'hFF, 1'b0}, // R7 buffer refilled
    {8'd8,  8'hF0, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0}, // R8 idle status
    {8'd6,  8'h40, 8'h00, 8'h0D, 8'hA5, 8'h00, 1'b1}, // R6
    {8'd6,  8'h30, 8'h01, 8'h2D, 8'h00, 8'hA5, 1'b0}, // R6 bit order, 301 wraps to 13
    {8'd6,  8'h99, 8'h00, 8'h05, 8'hEE, 8'h00, 1'b0}, // R6 unknown opcode
    {8'd6,  8'h30, 8'h00, 8'h05, 8'h00, 8'h5A, 1'b0}  // R6 unknown had no effect
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] op, input logic [7:0] ah, input logic [7:0] al,
                      input logic [7:0] din, output logic [7:0] rsp);
    logic [31:0] tx;
    logic [31:0] cap;
    tx  = {op, ah, al, din};
    cap = '0;
    for (int i = 31; i >= 0; i--) begin
      @(negedge clk);
      mosi = tx[i];
      repeat (HALF) @(negedge clk);
      cap[i] = miso;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    rsp = cap[7:0];
  endtask

  task automatic wait_idle();
    logic [7:0] st;
    int n;
    n = 0;
    st = 8'h01;
    while (st[0] && n < 30) begin
      xfer(8'hF0, 8'h00, 8'h00, 8'h00, st);
      n++;
    end
    check("R8 busy ends", st, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R8 watchdog: actual=timeout expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] r;
    repeat (5) @(negedge clk);
    check("R1 reset miso", {7'b0, miso}, 8'h00);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1: program mode low, frames ignored
    xfer(8'h10, 8'hA5, 8'h00, 8'h00, r);
    check("R1 enable while off", r, 8'h00);
    xfer(8'hF0, 8'h00, 8'h00, 8'h00, r);
    check("R1 status while off", r, 8'h00);

    prog_mode = 1'b1;
    repeat (5) @(negedge clk);
    xfer(8'h10, 8'hA5, 8'h00, 8'h00, r);
    xfer(8'h20, 8'h00, 8'h00, 8'h00, r);
    wait_idle();

    // R1: leaving program mode re-locks the session
    prog_mode = 1'b0;
    repeat (5) @(negedge clk);
    prog_mode = 1'b1;
    repeat (5) @(negedge clk);
    xfer(8'h30, 8'h00, 8'h06, 8'h00, r);
    check("R1 relocked read", r, 8'h00);
    // R2: write before unlock ignored
    xfer(8'h40, 8'h00, 8'h06, 8'hAB, r);
    check("R2 locked write rsp", r, 8'h00);
    // R3: wrong key keeps lock
    xfer(8'h10, 8'hA4, 8'h00, 8'h00, r);
    xfer(8'h30, 8'h00, 8'h06, 8'h00, r);
    check("R3 wrong key", r, 8'h00);
    xfer(8'h10, 8'hA5, 8'h00, 8'h00, r);
    xfer(8'h30, 8'h00, 8'h06, 8'h00, r);
    check("R2 ignored write left FF", r, 8'hFF);
    xfer(8'hF0, 8'h00, 8'h00, 8'h00, r);
    check("R2 not busy after ignored write", r, 8'h00);

    for (int v = 0; v < NVEC; v++) begin
      logic [48:0] e;
      e = VEC[v];
      xfer(e[40:33], e[32:25], e[24:17], e[16:9], r);
      checks++;
      if (r !== e[8:1]) begin
        errors++;
        $display("FAIL R%0d vector %0d: actual=%02h expected=%02h", e[48:41], v, r, e[8:1]);
      end
      if (e[0]) wait_idle();
    end

    // R8 / R9: busy flag and discard
    xfer(8'h40, 8'h00, 8'h08, 8'h44, r);
    xfer(8'hF0, 8'h00, 8'h00, 8'h00, r);
    check("R8 busy right after write", r, 8'h01);
    xfer(8'h40, 8'h00, 8'h09, 8'h55, r);
    wait_idle();
    xfer(8'h30, 8'h00, 8'h09, 8'h00, r);
    check("R9 write during busy dropped", r, 8'hFF);
    xfer(8'h30, 8'h00, 8'h08, 8'h00, r);
    check("R5 first write kept", r, 8'h44);

    // R8: interval length bracket
    xfer(8'h41, 8'h00, 8'h0A, 8'h66, r);
    repeat (1300) @(negedge clk);
    xfer(8'hF0, 8'h00, 8'h00, 8'h00, r);
    check("R8 still busy near end", r, 8'h01);
    xfer(8'hF0, 8'h00, 8'h00, 8'h00, r);
    check("R8 idle after interval", r, 8'h00);
    xfer(8'h31, 8'h00, 8'h0A, 8'h00, r);
    check("R5 data write after busy", r, 8'h66);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule